// File: doc/BRIEF.md
# GPIO Controller with Interrupt Detection

A general-purpose I/O block for up to 32 lines, reached through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read-data return. Software drives an output data register, either as a whole word or through atomic set and clear aliases. It also programs per-line direction and pull controls, which leave the block as level signals toward the pads. It reads back the line states after a two-flop synchroniser.

Each line has its own interrupt detector. Three per-line bits choose the trigger: a mode bit picks edge or level, a polarity bit picks rising/high or falling/low, and an any-edge bit makes every transition count. Edge events latch into a sticky raw status bit that stays until software writes a one to the clear register. In level mode the raw bit tracks the active level. A mask register hides lines from the masked view, and one interrupt output is the OR of the masked bits.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every readable register reads zero, and pin_out, pin_oe, pull_en, pull_sel and irq are all low.
- R2: A write to 0x00 loads the output register. A write to 0x10 sets the output bits where the write data holds a one. A write to 0x14 clears the output bits where it holds a one. Zero bits in a set or clear write leave the output unchanged. The output register drives pin_out.
- R3: Reading 0x04 returns the line states after two synchroniser flops. A pin change shows one cycle later than a single-flop path would.
- R4: The direction register at 0x08 drives pin_oe (1 = output). Pull enable at 0x18 drives pull_en, and pull select at 0x1C drives pull_sel.
- R5: Trigger selection uses three registers. Mode at 0x34: bit 1 means level, bit 0 means edge. Polarity at 0x3C: 0 means rising edge or high level, 1 means falling edge or low level. Any-edge at 0x38: in edge mode a 1 latches on both transitions, whatever the polarity bit.
- R6: A line sets raw status only while its enable bit at 0x20 is one. A disabled line in level mode shows zero raw status.
- R7: Writing a one to a bit of the clear register at 0x30 clears a latched edge status bit. An edge event in the same cycle wins over the clear.
- R8: An edge status bit stays set after the pin returns to its idle state. A level status bit follows the active level, so a clear has no lasting effect while the level is still active.
- R9: Raw status reads at 0x24. Masked status at 0x28 is raw AND NOT mask, where a mask bit at 0x2C of 1 hides the line. irq is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Raw line inputs (already filtered) |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per line |
| pull_en | output | 32 | Pull resistor enable per line |
| pull_sel | output | 32 | Pull direction select per line |
| irq | output | 1 | Combined interrupt request |

## Verification
The detector is tried with the five trigger settings: rising, falling, any-edge, high level and low level. Each setting gets one transition toward the active state and one away from it. The pairs tell a swapped polarity apart from a wrong mode decode, and they separate an any-edge path that ignores one direction. Directed sequences then cover these cases:
- a disabled line;
- a clear while an edge is latched, and a clear while a level is held;
- a masked line;
- the pin returning idle after an edge;
- set and clear patterns with mixed zero and one bits.

Together they separate sticky from level-following status and show whether a zero bit in an alias write wrongly disturbs the output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int OFS_DOUT    = 'h00;
   localparam int OFS_DIN     = 'h04;
   localparam int OFS_DIR     = 'h08;
   localparam int OFS_SET     = 'h10;
   localparam int OFS_CLR     = 'h14;
   localparam int OFS_PULLEN  = 'h18;
   localparam int OFS_PULLSEL = 'h1C;
   localparam int OFS_IEN     = 'h20;
   localparam int OFS_RAW     = 'h24;
   localparam int OFS_MASKED  = 'h28;
   localparam int OFS_MASK    = 'h2C;
   localparam int OFS_ICLR    = 'h30;
   localparam int OFS_MODE    = 'h34;
   localparam int OFS_ANYEDGE = 'h38;
   localparam int OFS_POL     = 'h3C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q      = stg[STAGES-1];
   assign q_prev = stg[STAGES];
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic prev,
   input  logic en,
   input  logic lvl_mode,
   input  logic pol,
   input  logic any_edge,
   input  logic clr,
   output logic raw
);
   logic rise, fall, edge_hit, lvl_hit;

   assign rise     = cur & ~prev;
   assign fall     = ~cur & prev;
   assign edge_hit = any_edge ? (rise | fall) : (pol ? fall : rise);
   assign lvl_hit  = cur ^ pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             raw <= 1'b0;
      else if (lvl_mode)      raw <= en & lvl_hit;
      else if (en && edge_hit) raw <= 1'b1;
      else if (clr)           raw <= 1'b0;
   end

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw && !lvl_mode && !clr) |=> raw);                        // R8
   AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && clr && !(en && edge_hit)) |=> !raw);          // R7
   AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw) |-> $past(en));                                  // R6
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int NPINS = 32,
   parameter int DW    = 32,
   parameter int AW    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pull_en,
   output logic [NPINS-1:0] pull_sel,
   output logic             irq
);
   import gpio_irq_pkg::*;

   generate
      if (NPINS > DW || NPINS < 1) begin : g_bad_pins
         $error("NPINS must be between 1 and DW");
      end
      if (AW < 7) begin : g_bad_aw
         $error("AW too narrow for register map");
      end
   endgenerate

   logic [NPINS-1:0] dout_q, dir_q, pen_q, psel_q, ien_q, mask_q, mode_q, any_q, pol_q;
   logic [NPINS-1:0] s_cur, s_prev, raw, masked, clr_vec, wd;

   function automatic logic hit(input logic [AW-1:0] a, input int ofs);
      return a == AW'(ofs);
   endfunction

   assign wd      = bus_wdata[NPINS-1:0];
   assign clr_vec = (bus_we && hit(bus_addr, OFS_ICLR)) ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0; dir_q <= '0; pen_q <= '0; psel_q <= '0;
         ien_q  <= '0; mask_q <= '0; mode_q <= '0; any_q <= '0; pol_q <= '0;
      end else if (bus_we) begin
         if (hit(bus_addr, OFS_DOUT))    dout_q <= wd;
         if (hit(bus_addr, OFS_SET))     dout_q <= dout_q | wd;
         if (hit(bus_addr, OFS_CLR))     dout_q <= dout_q & ~wd;
         if (hit(bus_addr, OFS_DIR))     dir_q  <= wd;
         if (hit(bus_addr, OFS_PULLEN))  pen_q  <= wd;
         if (hit(bus_addr, OFS_PULLSEL)) psel_q <= wd;
         if (hit(bus_addr, OFS_IEN))     ien_q  <= wd;
         if (hit(bus_addr, OFS_MASK))    mask_q <= wd;
         if (hit(bus_addr, OFS_MODE))    mode_q <= wd;
         if (hit(bus_addr, OFS_ANYEDGE)) any_q  <= wd;
         if (hit(bus_addr, OFS_POL))     pol_q  <= wd;
      end
   end

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(s_cur), .q_prev(s_prev)
   );

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         gpio_pin_irq u_det (
            .clk(clk), .rst_n(rst_n),
            .cur(s_cur[p]), .prev(s_prev[p]),
            .en(ien_q[p]), .lvl_mode(mode_q[p]), .pol(pol_q[p]),
            .any_edge(any_q[p]), .clr(clr_vec[p]), .raw(raw[p])
         );
      end
   endgenerate

   assign masked   = raw & ~mask_q;
   assign irq      = |masked;
   assign pin_out  = dout_q;
   assign pin_oe   = dir_q;
   assign pull_en  = pen_q;
   assign pull_sel = psel_q;

   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         OFS_DOUT:    bus_rdata = DW'(dout_q);
         OFS_DIN:     bus_rdata = DW'(s_cur);
         OFS_DIR:     bus_rdata = DW'(dir_q);
         OFS_PULLEN:  bus_rdata = DW'(pen_q);
         OFS_PULLSEL: bus_rdata = DW'(psel_q);
         OFS_IEN:     bus_rdata = DW'(ien_q);
         OFS_RAW:     bus_rdata = DW'(raw);
         OFS_MASKED:  bus_rdata = DW'(masked);
         OFS_MASK:    bus_rdata = DW'(mask_q);
         OFS_MODE:    bus_rdata = DW'(mode_q);
         OFS_ANYEDGE: bus_rdata = DW'(any_q);
         OFS_POL:     bus_rdata = DW'(pol_q);
         default:     bus_rdata = '0;
      endcase
   end

   AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit(bus_addr, OFS_SET)) |=>
      ((pin_out & $past(wd)) == $past(wd)) && ((pin_out & ~$past(wd)) == ($past(pin_out) & ~$past(wd)))); // R2
   AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit(bus_addr, OFS_CLR)) |=>
      ((pin_out & $past(wd)) == '0) && ((pin_out & ~$past(wd)) == ($past(pin_out) & ~$past(wd))));          // R2
   AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);                                                                                 // R9
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe, pull_en, pull_sel;
   logic        irq;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
      .pull_sel(pull_sel), .irq(irq)
   );

   // {mode, pol, anyedge, start, final, expected raw}
   localparam logic [5:0] VEC [10] = '{
      6'b000_01_1, 6'b000_10_0,   // rising
      6'b010_10_1, 6'b010_01_0,   // falling
      6'b001_01_1, 6'b011_10_1,   // any edge
      6'b100_01_1, 6'b100_10_0,   // level high
      6'b110_10_1, 6'b110_01_0    // level low
   };

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      clocks(3);
      rst_n = 1'b1;
      clocks(2);

      // R1 reset state
      rd(8'h00, r); chk("R1 dout", r, 0);
      rd(8'h24, r); chk("R1 raw", r, 0);
      rd(8'h34, r); chk("R1 mode", r, 0);
      chk("R1 pins", pin_out | pin_oe | pull_en | pull_sel, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R5 table walk, line 3
      wr(8'h20, 32'h8);
      for (int i = 0; i < 10; i++) begin
         logic [5:0] v;
         v = VEC[i];
         wr(8'h34, {28'd0, v[5], 3'd0});
         wr(8'h3C, {28'd0, v[4], 3'd0});
         wr(8'h38, {28'd0, v[3], 3'd0});
         pin_in = {28'd0, v[2], 3'd0};
         clocks(5);
         wr(8'h30, 32'hFFFF_FFFF);
         clocks(2);
         pin_in = {28'd0, v[1], 3'd0};
         clocks(5);
         rd(8'h24, r);
         chk($sformatf("R5 vector %0d raw", i), r, {28'd0, v[0], 3'd0});
         chk($sformatf("R9 vector %0d irq", i), {31'd0, irq}, {31'd0, v[0]});
      end

      // R2 output register and aliases
      wr(8'h00, 32'hA5A5_0000);
      wr(8'h10, 32'h0000_00FF);
      rd(8'h00, r); chk("R2 set", r, 32'hA5A5_00FF);
      wr(8'h14, 32'hA000_000F);
      chk("R2 clear pin_out", pin_out, 32'h05A5_00F0);

      // R4 direction and pulls
      wr(8'h08, 32'h0F0F_0F0F);
      wr(8'h18, 32'h1111_2222);
      wr(8'h1C, 32'h3333_4444);
      chk("R4 oe", pin_oe, 32'h0F0F_0F0F);
      chk("R4 pull_en", pull_en, 32'h1111_2222);
      chk("R4 pull_sel", pull_sel, 32'h3333_4444);

      // R3 two-flop synchroniser latency
      pin_in = 32'h0;
      clocks(4);
      @(negedge clk); pin_in = 32'h1234_5678;
      bus_addr = 8'h04;
      @(negedge clk); #1 chk("R3 after one clock", bus_rdata, 32'h0);
      @(negedge clk); #1 chk("R3 after two clocks", bus_rdata, 32'h1234_5678);

      // R6 disabled line: edge and level
      pin_in = 0;
      wr(8'h34, 0); wr(8'h3C, 0); wr(8'h38, 0);
      wr(8'h20, 0);
      clocks(4);
      wr(8'h30, 32'hFFFF_FFFF);
      pin_in = 32'h1;
      clocks(5);
      rd(8'h24, r); chk("R6 disabled edge", r, 0);
      wr(8'h34, 32'h1);
      clocks(3);
      rd(8'h24, r); chk("R6 disabled level", r, 0);

      // R7/R8 edge sticky and clear
      wr(8'h34, 0); wr(8'h20, 32'h1);
      pin_in = 0; clocks(4); wr(8'h30, 32'h1);
      pin_in = 32'h1; clocks(5);
      pin_in = 0; clocks(5);
      rd(8'h24, r); chk("R8 edge sticky", r, 32'h1);
      wr(8'h30, 32'h2);
      rd(8'h24, r); chk("R7 clear of other bit", r, 32'h1);
      wr(8'h30, 32'h1);
      rd(8'h24, r); chk("R7 clear", r, 0);

      // R8 level follows, clear has no lasting effect
      wr(8'h34, 32'h1);
      pin_in = 32'h1; clocks(5);
      wr(8'h30, 32'h1); clocks(1);
      rd(8'h24, r); chk("R8 level held", r, 32'h1);

      // R9 mask
      wr(8'h2C, 32'h1); clocks(1);
      rd(8'h28, r); chk("R9 masked hidden", r, 0);
      chk("R9 irq masked", {31'd0, irq}, 0);
      rd(8'h24, r); chk("R9 raw unaffected", r, 32'h1);
      wr(8'h2C, 32'h0);
      rd(8'h28, r); chk("R9 masked shown", r, 32'h1);
      chk("R9 irq shown", {31'd0, irq}, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule